// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is a down-counter with a level interrupt. The counter is 32 bits wide by default. A prescaler sets how often the counter moves. It can move on every clock, on every 16th clock or on every 256th clock. Software sets a mode, a rate select and an enable, and writes a start value. When the count is already zero and the next count step arrives, the interrupt flag is set.

What happens next depends on the mode. In free-running mode the count rolls over to all ones and keeps falling. In periodic mode it takes the stored start value again, so interrupts come at a steady interval of (start value + 1) steps. A write of the start value restarts counting at any moment. The count is always visible on an output. Reading it has no side effect.

Top module: `itv_timer`

## Requirements
- R1: After a synchronous active-high reset, the count output is 0, the stored start value is 0 and the interrupt output is 0.
- R2: A cycle with `load_we_i` high puts `load_val_i` on the count output after the next clock edge, whatever the enable, mode or current count. It also stores that value as the reload value.
- R3: With rate select code 2'b00 (every clock) and enable high, the count falls by one on each clock edge that has no start-value write.
- R4: With rate select code 2'b01 (every 16th clock) or 2'b10 (every 256th clock), after a start-value write the first count step comes 16 or 256 edges later, and later steps come every 16 or 256 edges. Both divisors are parameters. A start-value write also clears the prescaler's internal divide state.
- R5: With mode bit 0 (free-running), a count step taken at zero sets the interrupt and moves the count to all ones.
- R6: With mode bit 1 (periodic), a count step taken at zero sets the interrupt and moves the count to the stored start value.
- R7: The interrupt output stays high until `irq_clr_i` is asserted.
- R8: If a set event and `irq_clr_i` fall in the same cycle, the interrupt output is high after the edge.
- R9: `irq_clr_i` with no set event in that cycle makes the interrupt output low after the edge.
- R10: While enable is low, the count and the prescaler state hold and no interrupt is set. A start-value write still loads the count.
- R11: In periodic mode with a start value of 0, every count step sets the interrupt and the count stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Counting enable |
| mode_i | input | 1 | 0 = free-running (wrap), 1 = periodic (reload) |
| psel_i | input | 2 | Rate select: 00 every clock, 01 divide by DIV_MID, 10 or 11 divide by DIV_HIGH |
| load_we_i | input | 1 | Start-value write strobe; restarts counting |
| load_val_i | input | CNT_W | Start value written with the strobe |
| irq_clr_i | input | 1 | Interrupt clear |
| count_o | output | CNT_W | Live count |
| irq_o | output | 1 | Sticky interrupt level |

## Verification
The bench builds the timer with an 8-bit counter. With that width, the roll-over from zero to all ones in free-running mode takes only a few cycles to reach, and the wrapped value is 8'hFF. The two divisors keep their default values of 16 and 256. This means the real prescale spacing is measured edge by edge, including the full divide period that follows a restart in the middle of a count. The zero-start periodic case is used to line up a set event and a clear in the same cycle.

// File: rtl/itv_pkg.sv
package itv_pkg;

    typedef enum logic {
        MODE_FREE     = 1'b0,
        MODE_PERIODIC = 1'b1
    } itv_mode_e;

    typedef enum logic [1:0] {
        RATE_EVERY = 2'b00,
        RATE_MID   = 2'b01,
        RATE_HIGH  = 2'b10
    } itv_rate_e;

    // control bundle handed from the top to the counting core
    typedef struct packed {
        logic      restart;
        logic      step;
        itv_mode_e mode;
    } itv_ctrl_t;

    // divide ratio selected by a rate code; code 2'b11 behaves as the high ratio
    function automatic int unsigned rate_ratio(input logic [1:0] code,
                                               input int unsigned mid,
                                               input int unsigned high);
        int unsigned r;
        case (code)
            2'b00:   r = 1;
            2'b01:   r = mid;
            default: r = high;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/itv_prescaler.sv
module itv_prescaler
    import itv_pkg::*;
#(
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_HIGH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       restart,
    input  logic [1:0] psel,
    output logic       step
);
    localparam int unsigned DIV_W = (DIV_HIGH > 2) ? $clog2(DIV_HIGH) : 1;

    logic [DIV_W-1:0] div_q;
    logic             reached;
    int unsigned      ratio;

    always_comb begin
        ratio   = rate_ratio(psel, DIV_MID, DIV_HIGH);
        reached = (32'(div_q) + 32'd1) >= ratio;
        step    = en && !restart && reached;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (en) begin
            if (reached) div_q <= '0;
            else         div_q <= div_q + DIV_W'(1);
        end
    end

    p_no_step_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        !en |-> !step);

    p_every_clock_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !restart && psel == RATE_EVERY) |-> step);

    p_restart_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (restart && psel == RATE_MID && en) |=> (psel != RATE_MID) || !step);

    p_div_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(div_q));

endmodule

// File: rtl/itv_counter.sv
module itv_counter
    import itv_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  itv_ctrl_t        ctrl,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_hit
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        zero_hit = ctrl.step && !ctrl.restart && (cnt_q == '0);
        cnt_d    = cnt_q;
        if (ctrl.restart) begin
            cnt_d = load_val;
        end else if (ctrl.step) begin
            if (cnt_q != '0)                   cnt_d = cnt_q - CNT_W'(1);
            else if (ctrl.mode == MODE_PERIODIC) cnt_d = reload_q;
            else                               cnt_d = ALL_ONES;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (ctrl.restart) reload_q <= load_val;
        end
    end

    assign count = cnt_q;

    p_load_restart_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.restart |=> count == $past(load_val));

    p_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.step && !ctrl.restart && count != '0) |=> count == $past(count) - CNT_W'(1));

    p_hold_no_step_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.step && !ctrl.restart) |=> $stable(count));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (zero_hit && ctrl.mode == MODE_FREE) |=> count == ALL_ONES);

    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (zero_hit && ctrl.mode == MODE_PERIODIC) |=> count == reload_q);

endmodule

// File: rtl/itv_irq.sv
module itv_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)      irq_q <= 1'b0;
        else if (set) irq_q <= 1'b1;
        else if (clr) irq_q <= 1'b0;
    end

    assign irq = irq_q;

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set |=> irq);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !irq);

endmodule

// File: rtl/itv_timer.sv
module itv_timer
    import itv_pkg::*;
#(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned DIV_MID  = 16,
    parameter int unsigned DIV_HIGH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic [1:0]       psel_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             irq_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o
);
    logic      step;
    logic      zero_hit;
    itv_ctrl_t ctrl;

    itv_prescaler #(
        .DIV_MID  (DIV_MID),
        .DIV_HIGH (DIV_HIGH)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .en      (en_i),
        .restart (load_we_i),
        .psel    (psel_i),
        .step    (step)
    );

    always_comb begin
        ctrl.restart = load_we_i;
        ctrl.step    = step;
        ctrl.mode    = itv_mode_e'(mode_i);
    end

    itv_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .load_val (load_val_i),
        .count    (count_o),
        .zero_hit (zero_hit)
    );

    itv_irq u_irq (
        .clk (clk),
        .rst (rst),
        .set (zero_hit),
        .clr (irq_clr_i),
        .irq (irq_o)
    );

    p_no_irq_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !irq_o) |=> !irq_o);

    p_zero_periodic_r11: assert property (@(posedge clk) disable iff (rst)
        (step && !load_we_i && mode_i && count_o == '0 && u_cnt.reload_q == '0)
            |=> (irq_o && count_o == '0));

endmodule

// File: tb/itv_timer_tb_top.sv
`timescale 1ns/1ps
module itv_timer_tb_top;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          en_i;
    logic          mode_i;
    logic [1:0]    psel_i;
    logic          load_we_i;
    logic [CW-1:0] load_val_i;
    logic          irq_clr_i;
    logic [CW-1:0] count_o;
    logic          irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    itv_timer #(.CNT_W(CW), .DIV_MID(16), .DIV_HIGH(256)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .mode_i     (mode_i),
        .psel_i     (psel_i),
        .load_we_i  (load_we_i),
        .load_val_i (load_val_i),
        .irq_clr_i  (irq_clr_i),
        .count_o    (count_o),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [CW-1:0] v);
        load_we_i  = 1'b1;
        load_val_i = v;
        @(negedge clk);
        load_we_i  = 1'b0;
    endtask

    task automatic clear_irq();
        en_i      = 1'b0;
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; en_i = 0; mode_i = 0; psel_i = 0;
        load_we_i = 0; load_val_i = 0; irq_clr_i = 0;
        cycles(3);
        rst = 1'b0;
        check("R1 count after reset", 32'(count_o), 0);
        check("R1 irq after reset", 32'(irq_o), 0);
    endtask

    task automatic t_periodic_div1();
        en_i = 1; mode_i = 1; psel_i = 2'b00;
        do_load(8'd5);
        check("R2 load value", 32'(count_o), 5);
        cycles(3);
        check("R3 decrement", 32'(count_o), 2);
        cycles(2);
        check("R6 at zero, no irq yet", 32'(irq_o), 0);
        check("R3 reached zero", 32'(count_o), 0);
        cycles(1);
        check("R6 irq set", 32'(irq_o), 1);
        check("R6 reload", 32'(count_o), 5);
        cycles(2);
        check("R7 irq sticky", 32'(irq_o), 1);
        clear_irq();
        check("R9 irq cleared", 32'(irq_o), 0);
    endtask

    task automatic t_free_wrap();
        en_i = 1; mode_i = 0; psel_i = 2'b00;
        do_load(8'd3);
        cycles(4);
        check("R5 irq on zero", 32'(irq_o), 1);
        check("R5 wrap to all ones", 32'(count_o), 32'hFF);
        cycles(1);
        check("R5 keeps counting", 32'(count_o), 32'hFE);
        clear_irq();
    endtask

    task automatic t_disable_hold();
        logic [CW-1:0] snap;
        en_i = 1; mode_i = 0; psel_i = 2'b00;
        do_load(8'd50);
        cycles(4);
        en_i = 0;
        cycles(1);
        snap = count_o;
        cycles(10);
        check("R10 count held", 32'(count_o), 32'(snap));
        check("R10 no irq", 32'(irq_o), 0);
        // short count while disabled: reaching would need steps
        do_load(8'd0);
        check("R10 load while disabled", 32'(count_o), 0);
        cycles(5);
        check("R10 no irq at zero disabled", 32'(irq_o), 0);
    endtask

    task automatic t_prescale();
        en_i = 1; mode_i = 1; psel_i = 2'b01;
        do_load(8'd2);
        cycles(15);
        check("R4 div16 no step yet", 32'(count_o), 2);
        cycles(1);
        check("R4 div16 first step", 32'(count_o), 1);
        cycles(16);
        check("R4 div16 second step", 32'(count_o), 0);
        psel_i = 2'b10;
        do_load(8'd1);
        cycles(255);
        check("R4 div256 no step yet", 32'(count_o), 1);
        cycles(1);
        check("R4 div256 first step", 32'(count_o), 0);
        en_i = 0;
        clear_irq();
    endtask

    task automatic t_restart_mid();
        en_i = 1; mode_i = 1; psel_i = 2'b01;
        do_load(8'd9);
        cycles(20);
        check("R4 mid count", 32'(count_o), 8);
        do_load(8'd7);
        check("R2 restart value", 32'(count_o), 7);
        cycles(15);
        check("R4 divider reset on restart", 32'(count_o), 7);
        cycles(1);
        check("R4 full period after restart", 32'(count_o), 6);
        en_i = 0;
    endtask

    task automatic t_zero_periodic();
        clear_irq();
        en_i = 1; mode_i = 1; psel_i = 2'b00;
        do_load(8'd0);
        check("R11 loaded zero", 32'(count_o), 0);
        cycles(1);
        check("R11 irq each step", 32'(irq_o), 1);
        check("R11 count stays zero", 32'(count_o), 0);
        irq_clr_i = 1;
        cycles(1);
        check("R8 set beats clear", 32'(irq_o), 1);
        cycles(2);
        check("R11 still zero", 32'(count_o), 0);
        en_i = 0;
        cycles(1);
        check("R9 clear without set", 32'(irq_o), 0);
        irq_clr_i = 0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_periodic_div1();
        t_free_wrap();
        t_disable_hold();
        t_prescale();
        t_restart_mid();
        t_zero_periodic();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule